// File: doc/BRIEF.md
# Output Compare Waveform Channel

This block is one compare channel paired with a free-running up counter. The counter advances by one on every clock while its run input is high and returns to zero after it reaches a programmable reload value, so one period is reload + 1 clocks. When the counter value equals the channel's active compare value, the channel's output reference is driven high, driven low, toggled or left alone, as a two-bit mode field selects. On the same event a sticky compare flag is raised, and that flag is gated separately into an interrupt line and a DMA request line.

The compare value is loaded through a write strobe. With shadowing off, the write takes effect on the next clock, so the waveform can be reshaped while the counter runs. With shadowing on, the write goes to a holding register, and the active value picks it up only on the clock where the counter wraps to zero. The output reference passes a polarity stage and an output-enable stage before it reaches the pin. The reference is a two-state machine: REF_LOW and REF_HIGH. On a match, SET goes to REF_HIGH, CLEAR goes to REF_LOW, TOGGLE swaps the state, and FROZEN keeps it. With no match the state is held.

Top module: `oc_wave_channel`

## Requirements
- R1: After reset the counter is 0. It holds its value while `cnt_en` is 0 and increases by 1 on each clock while `cnt_en` is 1.
- R2: When `cnt_en` is 1 and the counter equals `reload_val`, the next clock sets it to 0, which gives a period of `reload_val` + 1 clocks.
- R3: A match is a cycle with `cnt_en` = 1 and counter equal to the active compare value. On the clock that ends a match cycle, the reference follows `mode`: 2'b00 keeps it, 2'b01 sets it to 1, 2'b10 clears it to 0, 2'b11 inverts it.
- R4: The clock that ends a match cycle sets `cmp_flag` to 1, and it stays 1 until it is cleared.
- R5: `flag_clr` = 1 clears `cmp_flag` on the next clock. If a match happens in the same cycle, the flag is set instead.
- R6: `irq` equals `cmp_flag` AND `irq_en`, and `dma_req` equals `cmp_flag` AND `dma_en`.
- R7: With `shadow_en` = 0, a write (`cmp_wr` = 1) replaces the active compare value on the next clock, including while the counter runs.
- R8: With `shadow_en` = 1, a write changes only the holding register. The active value loads from it on the clock where the counter wraps to 0.
- R9: With `out_en` = 1, `oc_pin` equals the reference XOR `polarity` (`polarity` = 1 means active low).
- R10: With `out_en` = 0, `oc_pin` sits at the inactive level, which equals `polarity`.
- R11: Reset clears the reference, the flag, the active compare value and the holding register.
- R12: No match happens while `cnt_en` is 0. A compare value above `reload_val` never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter run enable |
| reload_val | input | CNT_W | Last count value before the wrap |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| shadow_en | input | 1 | 1: buffer writes until the wrap |
| mode | input | 2 | Match action: 00 keep, 01 set, 10 clear, 11 toggle |
| polarity | input | 1 | 1 inverts the pin (active low) |
| out_en | input | 1 | Lets the reference reach the pin |
| flag_clr | input | 1 | Clears the compare flag |
| irq_en | input | 1 | Interrupt gate |
| dma_en | input | 1 | DMA request gate |
| count | output | CNT_W | Current counter value |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| oc_pin | output | 1 | Channel output pin |

## Verification
A table of vectors covers each mode. Each vector stops the counter one clock before the compare count and then exactly at it, which checks that the edge gives no off-by-one error. Runs of one, two and several periods are used under toggle, so one wrap and two wraps can be told apart, and this includes a 100-clock period with the match at count 3. Polarity and output-enable are tried against the same set and toggle patterns, so the inversion and the inactive level are seen separately. Directed runs write the compare value through each path and cross a wrap, so the point where the value takes effect tells the immediate and buffered paths apart. Other directed runs set and clear the flag in the same cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [1:0] {
        OCM_FROZEN = 2'b00,
        OCM_SET    = 2'b01,
        OCM_CLEAR  = 2'b10,
        OCM_TOGGLE = 2'b11
    } oc_mode_e;

    typedef enum logic {
        REF_LOW  = 1'b0,
        REF_HIGH = 1'b1
    } ref_state_e;

endpackage

// File: rtl/oc_upcount.sv
module oc_upcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    assign wrap  = run && (count_q == reload);
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (wrap)
            count_q <= '0;
        else if (run)
            count_q <= count_q + ONE;
    end

    // R1: an idle counter keeps its value
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count_q == $past(count_q)));

    // R2: reaching the reload value while running returns to zero
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_q == reload) |=> (count_q == '0));

endmodule

// File: rtl/oc_cmp_hold.sv
module oc_cmp_hold #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             shadow_en,
    input  logic             run,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    output logic             match
);
    logic [CNT_W-1:0] active_q;
    logic [CNT_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            hold_q   <= '0;
        end else begin
            if (wr)
                hold_q <= wdata;
            if (!shadow_en) begin
                if (wr)
                    active_q <= wdata;
            end else if (wrap) begin
                active_q <= wr ? wdata : hold_q;
            end
        end
    end

    assign match = run && (count == active_q);

    // R7: an unbuffered write lands on the next clock
    assert_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_en && wr) |=> (active_q == $past(wdata)));

    // R8: a buffered active value only moves at the wrap
    assert_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en && !wrap) |=> $stable(active_q));

    // R12: a stopped counter never matches
    assert_nomatch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !match);

endmodule

// File: rtl/oc_ref_out.sv
module oc_ref_out
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     match,
    input  oc_mode_e mode,
    input  logic     flag_clr,
    input  logic     polarity,
    input  logic     out_en,
    input  logic     irq_en,
    input  logic     dma_en,
    output logic     flag,
    output logic     irq,
    output logic     dma_req,
    output logic     pin
);
    ref_state_e state_q, state_d;
    logic       flag_q;

    always_comb begin
        state_d = state_q;
        if (match) begin
            unique case (mode)
                OCM_FROZEN: state_d = state_q;
                OCM_SET:    state_d = REF_HIGH;
                OCM_CLEAR:  state_d = REF_LOW;
                OCM_TOGGLE: state_d = (state_q == REF_HIGH) ? REF_LOW : REF_HIGH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= REF_LOW;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (match)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    always_comb begin
        flag    = flag_q;
        irq     = flag_q & irq_en;
        dma_req = flag_q & dma_en;
        pin     = out_en ? ((state_q == REF_HIGH) ^ polarity) : polarity;
    end

    // R3: set and clear modes force the reference level
    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OCM_SET) |=> (state_q == REF_HIGH));
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OCM_CLEAR) |=> (state_q == REF_LOW));
    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OCM_TOGGLE) |=> (state_q != $past(state_q)));
    assert_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(state_q));

    // R4: a match raises the flag
    assert_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q);

    // R5: clear without match drops the flag
    assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !match) |=> !flag_q);

endmodule

// File: rtl/oc_wave_channel.sv
module oc_wave_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             shadow_en,
    input  logic [1:0]       mode,
    input  logic             polarity,
    input  logic             out_en,
    input  logic             flag_clr,
    input  logic             irq_en,
    input  logic             dma_en,
    output logic [CNT_W-1:0] count,
    output logic             cmp_flag,
    output logic             irq,
    output logic             dma_req,
    output logic             oc_pin
);
    logic wrap;
    logic match;

    oc_upcount #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cnt_en),
        .reload (reload_val),
        .count  (count),
        .wrap   (wrap)
    );

    oc_cmp_hold #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cmp_wr),
        .wdata     (cmp_wdata),
        .shadow_en (shadow_en),
        .run       (cnt_en),
        .wrap      (wrap),
        .count     (count),
        .match     (match)
    );

    oc_ref_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .mode     (oc_mode_e'(mode)),
        .flag_clr (flag_clr),
        .polarity (polarity),
        .out_en   (out_en),
        .irq_en   (irq_en),
        .dma_en   (dma_en),
        .flag     (cmp_flag),
        .irq      (irq),
        .dma_req  (dma_req),
        .pin      (oc_pin)
    );

    // R10: a disabled output rests at the inactive level
    assert_idle_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (oc_pin == polarity));

endmodule

// File: tb/tb_oc_wave_channel.sv
module tb_oc_wave_channel;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic [W-1:0] reload_val = '0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         shadow_en = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         polarity = 1'b0;
    logic         out_en = 1'b1;
    logic         flag_clr = 1'b0;
    logic         irq_en = 1'b0;
    logic         dma_en = 1'b0;
    logic [W-1:0] count;
    logic         cmp_flag, irq, dma_req, oc_pin;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    oc_wave_channel #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reload_val(reload_val),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .shadow_en(shadow_en),
        .mode(mode), .polarity(polarity), .out_en(out_en), .flag_clr(flag_clr),
        .irq_en(irq_en), .dma_en(dma_en), .count(count), .cmp_flag(cmp_flag),
        .irq(irq), .dma_req(dma_req), .oc_pin(oc_pin)
    );

    typedef struct packed {
        logic [15:0] rld;
        logic [15:0] cmp;
        logic [1:0]  md;
        logic        pol;
        logic        oen;
        logic [15:0] n;
        logic        pin;
        logic        flg;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'd9,  16'd3, 2'b01, 1'b0, 1'b1, 16'd3,   1'b0, 1'b0},
        '{16'd9,  16'd3, 2'b01, 1'b0, 1'b1, 16'd4,   1'b1, 1'b1},
        '{16'd9,  16'd3, 2'b10, 1'b1, 1'b1, 16'd5,   1'b1, 1'b1},
        '{16'd9,  16'd3, 2'b11, 1'b0, 1'b1, 16'd4,   1'b1, 1'b1},
        '{16'd9,  16'd3, 2'b11, 1'b0, 1'b1, 16'd13,  1'b1, 1'b1},
        '{16'd9,  16'd3, 2'b11, 1'b0, 1'b1, 16'd14,  1'b0, 1'b1},
        '{16'd9,  16'd3, 2'b00, 1'b0, 1'b1, 16'd20,  1'b0, 1'b1},
        '{16'd9,  16'd3, 2'b01, 1'b1, 1'b1, 16'd4,   1'b0, 1'b1},
        '{16'd9,  16'd3, 2'b01, 1'b1, 1'b0, 16'd4,   1'b1, 1'b1},
        '{16'd9,  16'd3, 2'b01, 1'b0, 1'b0, 16'd4,   1'b0, 1'b1},
        '{16'd5,  16'd7, 2'b11, 1'b0, 1'b1, 16'd30,  1'b0, 1'b0},
        '{16'd5,  16'd0, 2'b01, 1'b0, 1'b1, 16'd1,   1'b1, 1'b1},
        '{16'd5,  16'd5, 2'b11, 1'b0, 1'b1, 16'd6,   1'b1, 1'b1},
        '{16'd5,  16'd5, 2'b11, 1'b0, 1'b1, 16'd12,  1'b0, 1'b1},
        '{16'd99, 16'd3, 2'b11, 1'b0, 1'b1, 16'd103, 1'b1, 1'b1},
        '{16'd99, 16'd3, 2'b11, 1'b0, 1'b1, 16'd104, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cnt_en = 1'b0;
        cmp_wr = 1'b0;
        flag_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cmp(input logic [W-1:0] v);
        @(negedge clk);
        cmp_wr = 1'b1;
        cmp_wdata = v;
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11 R1: reset state
        do_reset();
        check("R11 count", 32'(count), 0);
        check("R11 flag", 32'(cmp_flag), 0);
        check("R11 pin", 32'(oc_pin), 0);
        check("R6 irq at reset", 32'(irq), 0);

        // Table walk: R2 R3 R4 R9 R10 R12
        for (int k = 0; k < NV; k++) begin
            do_reset();
            reload_val = VECS[k].rld;
            mode       = VECS[k].md;
            polarity   = VECS[k].pol;
            out_en     = VECS[k].oen;
            shadow_en  = 1'b0;
            write_cmp(VECS[k].cmp);
            run(int'(VECS[k].n));
            check($sformatf("R3 R9 R10 pin vec%0d", k), 32'(oc_pin), 32'(VECS[k].pin));
            check($sformatf("R4 R12 flag vec%0d", k), 32'(cmp_flag), 32'(VECS[k].flg));
            check($sformatf("R2 count vec%0d", k), 32'(count),
                  32'(int'(VECS[k].n) % (int'(VECS[k].rld) + 1)));
        end

        // R1 R12: stopped counter with compare 0 neither counts nor matches
        do_reset();
        reload_val = 16'd9; mode = 2'b01; polarity = 1'b0; out_en = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 hold count", 32'(count), 0);
        check("R12 no match while stopped", 32'(cmp_flag), 0);

        // R6: gating of the flag
        write_cmp(16'd3);
        run(4);
        irq_en = 1'b0; dma_en = 1'b0; #1;
        check("R6 irq gated off", 32'(irq), 0);
        check("R6 dma gated off", 32'(dma_req), 0);
        irq_en = 1'b1; #1;
        check("R6 irq on", 32'(irq), 1);
        check("R6 dma still off", 32'(dma_req), 0);
        dma_en = 1'b1; #1;
        check("R6 dma on", 32'(dma_req), 1);
        irq_en = 1'b0; dma_en = 1'b0;

        // R5: clear and match in the same cycle, match wins
        do_reset();
        reload_val = 16'd9; mode = 2'b11;
        write_cmp(16'd3);
        @(negedge clk);
        flag_clr = 1'b1;
        cnt_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        cnt_en = 1'b0;
        check("R5 match beats clear", 32'(cmp_flag), 1);
        @(negedge clk);
        flag_clr = 1'b0;
        check("R5 clear alone", 32'(cmp_flag), 0);

        // R7: immediate write, changed mid-run
        do_reset();
        reload_val = 16'd9; mode = 2'b11; shadow_en = 1'b0;
        write_cmp(16'd3);
        run(2);
        write_cmp(16'd8);
        run(2);
        check("R7 old value abandoned", 32'(oc_pin), 0);
        run(5);
        check("R7 new value used", 32'(oc_pin), 1);

        // R7: write before start is live at count 0 check
        do_reset();
        write_cmp(16'd5);
        run(1);
        check("R7 no match at old zero", 32'(oc_pin), 0);

        // R8: buffered write waits for the wrap
        do_reset();
        reload_val = 16'd9; mode = 2'b11; shadow_en = 1'b1;
        write_cmp(16'd5);
        run(1);
        check("R8 reset value still active", 32'(oc_pin), 1);
        run(14);
        check("R8 no match at zero after wrap", 32'(oc_pin), 1);
        run(1);
        check("R8 loaded value matches", 32'(oc_pin), 0);
        shadow_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule